// File: doc/BRIEF.md
# GPIO Edge Interrupt Detector

This block watches a bank of already-synchronized GPIO input levels and turns selected level changes into latched interrupt requests. For every pin, software chooses independently whether a low-to-high transition, a high-to-low transition, both, or neither should be recorded. Each choice is held in its own enable register. That register is never written directly. One address ORs a mask into it, and a second address removes the bits given in a mask. Several drivers can therefore change their own pins without a read-modify-write sequence.

Recorded transitions accumulate in a status register. Software clears that register by writing ones to the bits it has handled. The bank is split into a lower and an upper half of pins. Each half raises its own level-sensitive interrupt line whenever any of its status bits is pending and that half is enabled in a small bank-enable register. The line stays high until every pending bit of the half has been cleared.

The register bus is a simple single-cycle strobe interface. A write takes effect at the clock edge that samples it. A read returns data on the cycle after the read strobe.

Top module: `gpio_edge_irq`

## Requirements
- R1: Word address 1 ORs `wr_data` into the rising-edge enable vector, and word address 2 clears the bits of that vector where `wr_data` is 1. A read of either address returns the vector.
- R2: Word address 3 ORs `wr_data` into the falling-edge enable vector, and word address 4 clears the bits of that vector where `wr_data` is 1. A read of either address returns the vector.
- R3: A pin whose rising and falling enables are both 0 never sets its status bit, whatever its level does.
- R4: A pin level of 1 where the previous cycle's level was 0 sets the pin's status bit if its rising enable is 1. A level of 0 after 1 sets the bit if its falling enable is 1. With both enables set, both kinds of transition set the bit.
- R5: A write to word address 5 clears each status bit where `wr_data` is 1 and leaves the bits where it is 0 unchanged. A read of address 5 returns the status.
- R6: Word address 0 holds the bank enables in bits [1:0] (read/write). `irq_out[0]` is the registered OR of status bits [15:0] gated by bit 0. `irq_out[1]` is the same for status bits [31:16] gated by bit 1. A line is 0 while its enable bit is 0.
- R7: An interrupt line stays at 1 while at least one status bit of its half remains set, and falls only once all of them are cleared.
- R8: If an enabled edge occurs in the same cycle as a status clear of that bit, the bit stays set.
- R9: After reset, the enable vectors, status, bank enables, `rd_data` and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wr_data | input | 32 | Write data / mask |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_out | output | 2 | Level interrupt per half bank |

## Verification
A status bit can be set by a new edge and cleared by software in the same clock cycle. The bench brings the two together on purpose. It first latches a rising edge on pin 0 and lets the pin fall again with no falling enable. It then raises the pin in the very cycle a clear mask for bit 0 is written. A following status read must still show bit 0 set, and a later clear with no edge must remove it. A second overlap arises between clearing one bit of a half and the other bits still pending. There the lower line is sampled after each partial clear to confirm it holds until the last bit goes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    REG_BANK_EN  = 3'd0,
    REG_RISE_SET = 3'd1,
    REG_RISE_CLR = 3'd2,
    REG_FALL_SET = 3'd3,
    REG_FALL_CLR = 3'd4,
    REG_STATUS   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/setclr_reg.sv
module setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_mask) & ~clr_mask;
  end

  // R1 / R2: bits written through the set address are held afterwards
  assert_set_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (clr_mask == '0) |=> ((q & $past(set_mask)) == $past(set_mask)));

  // R2: bits written through the clear address are removed
  assert_clr_removes_R2: assert property (@(posedge clk) disable iff (rst)
    (set_mask == '0) |=> ((q & $past(clr_mask)) == '0));
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hit
);
  logic [W-1:0] level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= level;
  end

  always_comb begin
    hit = (rise_en & level & ~level_q) | (fall_en & ~level & level_q);
  end

  // R3: no event on a pin with both enables cleared
  assert_no_hit_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    ((hit & ~(rise_en | fall_en)) == '0));
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int W      = 32,
  parameter int HALF_W = 16,
  localparam int NB    = W / HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  hit,
  input  logic [W-1:0]  clr_mask,
  input  logic [NB-1:0] bank_en,
  output logic [W-1:0]  status,
  output logic [NB-1:0] irq
);
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_mask) | hit;
  end

  for (genvar b = 0; b < NB; b++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq[b] <= 1'b0;
      else     irq[b] <= bank_en[b] & (|status[b*HALF_W +: HALF_W]);
    end

    // R6: a disabled half never drives its line
    assert_line_gated_R6: assert property (@(posedge clk) disable iff (rst)
      !bank_en[b] |=> !irq[b]);

    // R7: line holds while bits of the half are pending and the half is enabled
    assert_line_holds_R7: assert property (@(posedge clk) disable iff (rst)
      (bank_en[b] && (status[b*HALF_W +: HALF_W] != '0)) |=> irq[b]);
  end

  // R8: an edge always lands, even against a clear
  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(hit)) == $past(hit)));

  // R5: cleared bits without a new edge are gone
  assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(clr_mask & ~hit)) == '0));

  // R3 / R4: a bit only rises because of an edge
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(hit)) == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 3,
  localparam int NB    = NPINS / HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  rd_data,
  output logic [NB-1:0]     irq_out
);
  logic [NPINS-1:0] rise_set, rise_clr, fall_set, fall_clr, stat_clr;
  logic [NPINS-1:0] rise_en, fall_en, hit, status;
  logic [NB-1:0]    bank_en;
  logic [NPINS-1:0] rd_mux;

  always_comb begin
    rise_set = '0;
    rise_clr = '0;
    fall_set = '0;
    fall_clr = '0;
    stat_clr = '0;
    if (wr_en) begin
      case (addr)
        REG_RISE_SET: rise_set = wr_data;
        REG_RISE_CLR: rise_clr = wr_data;
        REG_FALL_SET: fall_set = wr_data;
        REG_FALL_CLR: fall_clr = wr_data;
        REG_STATUS:   stat_clr = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               bank_en <= '0;
    else if (wr_en && addr == REG_BANK_EN) bank_en <= wr_data[NB-1:0];
  end

  setclr_reg #(.W(NPINS)) u_rise (
    .clk(clk), .rst(rst), .set_mask(rise_set), .clr_mask(rise_clr), .q(rise_en));

  setclr_reg #(.W(NPINS)) u_fall (
    .clk(clk), .rst(rst), .set_mask(fall_set), .clr_mask(fall_clr), .q(fall_en));

  edge_detect #(.W(NPINS)) u_edge (
    .clk(clk), .rst(rst), .level(pin_in), .rise_en(rise_en), .fall_en(fall_en),
    .hit(hit));

  irq_status #(.W(NPINS), .HALF_W(HALF_W)) u_stat (
    .clk(clk), .rst(rst), .hit(hit), .clr_mask(stat_clr), .bank_en(bank_en),
    .status(status), .irq(irq_out));

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_BANK_EN:                rd_mux[NB-1:0] = bank_en;
      REG_RISE_SET, REG_RISE_CLR: rd_mux = rise_en;
      REG_FALL_SET, REG_FALL_CLR: rd_mux = fall_en;
      REG_STATUS:                 rd_mux = status;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  // R9: reset leaves the outputs quiet
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && rd_data == '0));
endmodule

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pin_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  irq_out;

  int tests = 0;
  int fails = 0;
  logic rd_pend = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  gpio_edge_irq u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out));

  always @(posedge clk) rd_pend <= rd_en;

  // monitor: pops the expected read results
  always @(negedge clk) begin
    if (rd_pend) begin
      item_t it;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: actual %h expected none", rd_data);
      end else begin
        it = sb.pop_front();
        tests++;
        if (rd_data !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.req, rd_data, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    sb.push_back('{exp: e, req: req});
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic [1:0] e, input string req);
    @(negedge clk);
    tests++;
    if (irq_out !== e) begin
      fails++;
      $display("FAIL %s: irq actual %b expected %b", req, irq_out, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk_irq(2'b00, "R9");
    rd(3'd5, 32'h0, "R9 status");
    rd(3'd1, 32'h0, "R9 rise");
    rd(3'd3, 32'h0, "R9 fall");
    rd(3'd0, 32'h0, "R9 bank");
    // R1 rising enable set/clear
    wr(3'd1, 32'h0000_0005);
    rd(3'd1, 32'h0000_0005, "R1 set");
    wr(3'd2, 32'h0000_0004);
    rd(3'd2, 32'h0000_0001, "R1 clr");
    wr(3'd1, 32'h0000_0004);
    // R2 falling enable
    wr(3'd3, 32'h0001_0002);
    wr(3'd4, 32'h0000_0002);
    rd(3'd4, 32'h0001_0000, "R2 set/clr");
    // R3 pin 1 unenabled toggles
    pins(32'h0000_0002);
    pins(32'h0000_0000);
    rd(3'd5, 32'h0, "R3");
    // R4 rising pin0, falling pin16 (its rise ignored)
    pins(32'h0001_0001);
    rd(3'd5, 32'h0000_0001, "R4 rise");
    pins(32'h0000_0001);
    rd(3'd5, 32'h0001_0001, "R4 fall");
    chk_irq(2'b00, "R6 gated");
    wr(3'd0, 32'h3);
    chk_irq(2'b11, "R6 enabled");
    // R5 W1C
    wr(3'd5, 32'h0);
    rd(3'd5, 32'h0001_0001, "R5 zero write");
    wr(3'd5, 32'h0000_0001);
    rd(3'd5, 32'h0001_0000, "R5 clear");
    chk_irq(2'b10, "R6 halves");
    wr(3'd0, 32'h1);
    chk_irq(2'b00, "R6 upper gated");
    wr(3'd0, 32'h3);
    wr(3'd5, 32'h0001_0000);
    // R7 two pending bits in the low half
    pins(32'h0000_0000);
    pins(32'h0000_0005);
    rd(3'd5, 32'h0000_0005, "R7 pending");
    wr(3'd5, 32'h0000_0001);
    chk_irq(2'b01, "R7 hold");
    wr(3'd5, 32'h0000_0004);
    chk_irq(2'b00, "R7 release");
    // R4 both edges on pin0
    wr(3'd3, 32'h0000_0001);
    pins(32'h0000_0004);
    rd(3'd5, 32'h0000_0001, "R4 both fall");
    wr(3'd5, 32'h0000_0001);
    pins(32'h0000_0005);
    rd(3'd5, 32'h0000_0001, "R4 both rise");
    wr(3'd5, 32'h0000_0001);
    // R8 edge coincident with clear
    wr(3'd4, 32'h0000_0001);
    pins(32'h0000_0004);
    pins(32'h0000_0005);
    pins(32'h0000_0004);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd5; wr_data = 32'h0000_0001; pin_in = 32'h0000_0005;
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd5, 32'h0000_0001, "R8 edge wins");
    wr(3'd5, 32'h0000_0001);
    rd(3'd5, 32'h0, "R8 later clear");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule